// File: doc/BRIEF.md
# Inter-core set/clear mailbox bank

The block holds sixteen 32-bit mailboxes, four for each of four cores, used by software on one core to signal another. Software reaches the mailboxes over a simple 32-bit register bus. Writing to the set window ORs the write data into the addressed mailbox. Writing to the clear window clears every mailbox bit whose write-data bit is 1 and leaves the others unchanged. Reading the clear window returns the mailbox contents.

For each mailbox the block drives a flag that is high while the mailbox holds any nonzero bit. An interrupt router elsewhere takes the four flags of a core as that core's mailbox sources 4 to 7. Enabling and routing those sources is not done here. The flags come straight from the stored mailbox state, so they change in the cycle after the write that changes a mailbox.

The bus side is a two-state machine. In `ST_IDLE` nothing is being returned. A read request in any state moves it to `ST_RESP`, in which `rd_valid` is high and `rd_data` carries the value captured on the request cycle. A cycle without a read request returns it to `ST_IDLE`.

Top module: `xcore_mbox_bank`

## Requirements
- R1: While reset is asserted and after it is released, all mailboxes read zero, `mbox_pending` is zero and `rd_valid` is low.
- R2: A write to byte address 0x80 + 4·k (k = 0..15) ORs `req_wdata` into mailbox k. The set window spans 0x80 to 0xBF.
- R3: A write to byte address 0xC0 + 4·k clears each bit of mailbox k whose `req_wdata` bit is 1 and keeps every other bit. The clear window spans 0xC0 to 0xFF.
- R4: A read at 0xC0 + 4·k returns mailbox k on `rd_data`, with `rd_valid` high, in the cycle after the request. `rd_valid` is low in every cycle that does not follow a read request.
- R5: A read anywhere in the set window returns zero with `rd_valid` high.
- R6: `mbox_pending[4·c + j]` is high exactly when mailbox j of core c (mailbox number 4·c + j) is nonzero. It is updated in the cycle after the write.
- R7: A write below 0x80 changes no mailbox, and a read there returns zero.
- R8: Address bits 1:0 are ignored, so every access acts on a whole 32-bit word.
- R9: A read does not change the contents of any mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (state `ST_RESP`) |
| rd_data | output | 32 | Read data, zero when `rd_valid` is low |
| mbox_pending | output | 16 | Nonzero flag per mailbox, bit 4·c+j for core c, slot j |

## Verification
The assertions check the following on every cycle:
- `rd_valid` follows a read request one cycle later, and is low otherwise.
- A set-window write never lowers a pending flag.
- A clear-window write never raises a pending flag.
- Out-of-window writes and cycles without a write leave the flags unchanged.
- Set-window reads return zero.

The bench's scenarios show what a property over the ports alone cannot:
- The exact bit values after OR and write-one-to-clear.
- Which mailbox an address selects, including the first and last word of each window and unaligned addresses.
- That reads leave the contents unchanged.

These are checked against a bench reference model of all sixteen mailboxes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Which address window a bus access falls into.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // Bus-side response state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned     AW       = 8,
    parameter int unsigned     NMB      = 16,
    parameter int unsigned     IW       = 4,
    parameter logic [AW-1:0]   SET_BASE = 8'h80,
    parameter logic [AW-1:0]   CLR_BASE = 8'hC0
) (
    input  logic [AW-1:0] addr,
    output win_e          win,
    output logic [IW-1:0] idx
);
    localparam logic [31:0] SPAN = 32'(NMB * 4);
    localparam logic [31:0] SB   = 32'(SET_BASE);
    localparam logic [31:0] CB   = 32'(CLR_BASE);

    logic [31:0] a;
    logic [31:0] off;

    always_comb begin
        a   = 32'(addr);
        win = WIN_NONE;
        off = '0;
        if (a >= SB && a < SB + SPAN) begin
            win = WIN_SET;
            off = a - SB;
        end else if (a >= CB && a < CB + SPAN) begin
            win = WIN_CLR;
            off = a - CB;
        end
        // byte offset to word index; low two bits dropped
        idx = off[IW+1:2];
    end

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter int unsigned NMB = 16,
    parameter int unsigned IW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  win_e                    win,
    input  logic [IW-1:0]           idx,
    input  logic [DW-1:0]           wdata,
    output logic [NMB-1:0][DW-1:0]  mb_q,
    output logic [NMB-1:0]          nz
);
    for (genvar k = 0; k < NMB; k++) begin : g_mb
        logic [DW-1:0] r;
        logic          set_hit;
        logic          clr_hit;

        assign set_hit = wr_en && (win == WIN_SET) && (idx == IW'(k));
        assign clr_hit = wr_en && (win == WIN_CLR) && (idx == IW'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r <= '0;
            end else if (set_hit) begin
                r <= r | wdata;
            end else if (clr_hit) begin
                r <= r & ~wdata;
            end
        end

        assign mb_q[k] = r;
        assign nz[k]   = |r;
    end

endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux
    import mbx_pkg::*;
#(
    parameter int unsigned DW  = 32,
    parameter int unsigned NMB = 16,
    parameter int unsigned IW  = 4
) (
    input  win_e                    win,
    input  logic [IW-1:0]           idx,
    input  logic [NMB-1:0][DW-1:0]  mb_q,
    output logic [DW-1:0]           rdata
);
    always_comb begin
        rdata = '0;
        if (win == WIN_CLR) begin
            rdata = mb_q[idx];
        end
    end

endmodule

// File: rtl/xcore_mbox_bank.sv
module xcore_mbox_bank
    import mbx_pkg::*;
#(
    parameter int unsigned   CORES    = 4,
    parameter int unsigned   PER_CORE = 4,
    parameter int unsigned   DW       = 32,
    parameter int unsigned   AW       = 8,
    parameter logic [AW-1:0] SET_BASE = 8'h80,
    parameter logic [AW-1:0] CLR_BASE = 8'hC0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [AW-1:0]             req_addr,
    input  logic [DW-1:0]             req_wdata,
    output logic                      rd_valid,
    output logic [DW-1:0]             rd_data,
    output logic [CORES*PER_CORE-1:0] mbox_pending
);
    localparam int unsigned NMB = CORES * PER_CORE;
    localparam int unsigned IW  = (NMB > 1) ? $clog2(NMB) : 1;

    win_e                    win;
    logic [IW-1:0]           idx;
    logic [NMB-1:0][DW-1:0]  mb_q;
    logic [NMB-1:0]          nz;
    logic [DW-1:0]           mux_data;
    logic                    wr_en;
    logic                    rd_req;

    assign wr_en  = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    mbx_decode #(
        .AW(AW), .NMB(NMB), .IW(IW),
        .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .addr(req_addr),
        .win (win),
        .idx (idx)
    );

    mbx_store #(.DW(DW), .NMB(NMB), .IW(IW)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .win  (win),
        .idx  (idx),
        .wdata(req_wdata),
        .mb_q (mb_q),
        .nz   (nz)
    );

    mbx_rdmux #(.DW(DW), .NMB(NMB), .IW(IW)) u_rdmux (
        .win  (win),
        .idx  (idx),
        .mb_q (mb_q),
        .rdata(mux_data)
    );

    // Bus response state machine.
    bus_st_e       st_q;
    bus_st_e       st_d;
    logic [DW-1:0] hold_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = rd_req ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_req) begin
                hold_q <= mux_data;
            end
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RESP: begin
                rd_valid = 1'b1;
                rd_data  = hold_q;
            end
            default: ;
        endcase
    end

    assign mbox_pending = nz;

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int unsigned DW       = 32,
    parameter int unsigned AW       = 8,
    parameter int unsigned NMB      = 16,
    parameter int unsigned SET_LO   = 32'h80,
    parameter int unsigned CLR_LO   = 32'hC0
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_write,
    input logic [AW-1:0]  req_addr,
    input logic           rd_valid,
    input logic [DW-1:0]  rd_data,
    input logic [NMB-1:0] mbox_pending
);
    localparam int unsigned SPAN = NMB * 4;

    logic in_set;
    logic in_clr;
    logic rd_req;
    logic wr_req;

    assign in_set = (32'(req_addr) >= SET_LO) && (32'(req_addr) < SET_LO + SPAN);
    assign in_clr = (32'(req_addr) >= CLR_LO) && (32'(req_addr) < CLR_LO + SPAN);
    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    assert_reset_clean_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mbox_pending == '0) && !rd_valid);

    assert_set_keeps_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req && in_set) |-> ((mbox_pending & $past(mbox_pending)) == $past(mbox_pending)));

    assert_clear_raises_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req && in_clr) |-> ((mbox_pending & ~$past(mbox_pending)) == '0));

    assert_resp_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req) |-> rd_valid);

    assert_no_spurious_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req) |-> !rd_valid);

    assert_set_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && in_set) |-> (rd_data == '0));

    assert_idle_flags_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_req) |-> $stable(mbox_pending));

    assert_outside_write_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_req && !in_set && !in_clr) |-> $stable(mbox_pending));

endmodule

bind xcore_mbox_bank mbx_bank_chk #(
    .DW(DW), .AW(AW), .NMB(CORES*PER_CORE),
    .SET_LO(32'(SET_BASE)), .CLR_LO(32'(CLR_BASE))
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .mbox_pending(mbox_pending)
);

// File: tb/sim_xcore_mbox_bank.sv
`timescale 1ns/1ps
module sim_xcore_mbox_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [15:0] mbox_pending;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [16];

    always #2 clk = ~clk;

    xcore_mbox_bank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .mbox_pending(mbox_pending)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pending();
        logic [15:0] p;
        for (int k = 0; k < 16; k++) p[k] = (model[k] != 0);
        return p;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a >= 8'hC0) return model[(a - 8'hC0) >> 2];
        return 32'h0;
    endfunction

    function automatic void apply_write(input logic [7:0] a, input logic [31:0] d);
        if (a >= 8'hC0)      model[(a - 8'hC0) >> 2] = model[(a - 8'hC0) >> 2] & ~d;
        else if (a >= 8'h80) model[(a - 8'h80) >> 2] = model[(a - 8'h80) >> 2] | d;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        apply_write(a, d);
        chk({req, " pending"}, 32'(mbox_pending), 32'(exp_pending()));
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [31:0] e;
        e = exp_read(a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({req, " rd_data"}, rd_data, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) model[k] = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pending in reset", 32'(mbox_pending), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pending after reset", 32'(mbox_pending), 32'h0);
        chk("R1 rd_valid after reset", 32'(rd_valid), 32'h0);
        for (int k = 0; k < 16; k++) rd(8'(8'hC0 + 4 * k), "R1 mailbox zero");

        // R2 window edges and OR behaviour
        wr(8'h80, 32'h0000_00F0, "R2 first set");
        wr(8'h80, 32'h0000_000F, "R2 or merge");
        rd(8'hC0, "R2 merged value");
        wr(8'hBC, 32'h8000_0001, "R2 last set");
        rd(8'hFC, "R2 last mailbox");
        // R6 mapping: core 2 slot 1 is mailbox 9 -> pending bit 9
        wr(8'h80 + 8'd36, 32'h0001_0000, "R6 core2 slot1");
        chk("R6 bit9", 32'(mbox_pending[9]), 32'd1);
        // R3 partial and full clear
        wr(8'hC0, 32'h0000_0011, "R3 partial clear");
        rd(8'hC0, "R3 remaining bits");
        wr(8'hFC, 32'hFFFF_FFFF, "R3 full clear");
        chk("R6 bit15 cleared", 32'(mbox_pending[15]), 32'd0);
        // R5 set-window reads
        rd(8'h80, "R5 set window read");
        rd(8'hA4, "R5 set window read mb9");
        // R7 outside writes and reads
        wr(8'h7C, 32'hFFFF_FFFF, "R7 write 0x7C");
        wr(8'h00, 32'h1234_5678, "R7 write 0x00");
        for (int k = 0; k < 16; k++) rd(8'(8'hC0 + 4 * k), "R7 contents kept");
        rd(8'h40, "R7 read outside");
        // R8 unaligned addresses
        wr(8'h87, 32'h0000_0100, "R8 unaligned set");
        rd(8'hC5, "R8 unaligned read");
        wr(8'hC6, 32'h0000_0100, "R8 unaligned clear");
        rd(8'hC4, "R8 after clear");
        // R9 reads are not destructive
        rd(8'hA4 + 8'h40, "R9 first read");
        rd(8'hA4 + 8'h40, "R9 second read");
        // R4 back-to-back reads
        rd(8'hC0, "R4 back to back a");
        rd(8'hE4, "R4 back to back b");

        // Constrained random traffic
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            int unsigned sel;
            logic [7:0]  a;
            logic [31:0] d;
            sel = $urandom_range(0, 99);
            a   = 8'($urandom_range(0, 255));
            if (sel < 35) begin
                a = 8'h80 | (a & 8'h3F);
                d = $urandom() & $urandom();
                wr(a, d, "R2 random set");
            end else if (sel < 65) begin
                a = 8'hC0 | (a & 8'h3F);
                d = ($urandom_range(0, 1) == 1) ? model[(a - 8'hC0) >> 2] : $urandom();
                wr(a, d, "R3 random clear");
            end else if (sel < 70) begin
                wr(a & 8'h7F & ~8'h00, $urandom(), "R7 random outside");
            end else begin
                rd(a, "R4 random read");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule